// File: doc/BRIEF.md
# Variable-Length Micro-Cycle Sequencer

This block steps a bit-serial, microcoded processor through its control store. It keeps an 8-bit micro-address made of a 4-bit upper half and a 4-bit lower half, and presents that address to an external control-store ROM. It latches the returned 28-bit micro-word, then runs a micro-cycle whose number of shift clocks is chosen by that word. During the cycle it drives a shift enable for the serial data path, and it flags the last clock of the cycle. It also presents the word's data-path control fields for as long as the word is active.

The next micro-address is never loaded and never incremented. Each half of the current address is XORed with a 4-bit modifier taken from the word. A branch-enable bit lets the upper modifier also pick one of sixteen status conditions, and the state of that condition flips the lowest address bit. A special combination of word bits replaces the upper modifier with bits of the instruction register, which gives a multi-way dispatch. A condition can also silence the shift enable for a whole cycle without shortening it. A ready input holds the sequence in the overhead clock, so a memory or refresh engine can stall the processor at a clean boundary.

Top module: `useq_core`

## Requirements
- R1: The micro-word length field (bits [11:8], value L) gives a body of exactly L+1 clocks. Each body clock that is not suppressed asserts `shift_en`, and `cyc_end` is high only on the last body clock.
- R2: Every micro-cycle starts with one overhead clock in which `shift_en` and `cyc_end` are low, so a cycle with no stall lasts L+2 clocks.
- R3: The address is {upper[7:4], lower[3:0]}. At the end of a cycle, the upper half becomes upper XOR word[3:0] and the lower half becomes lower XOR word[7:4]. The address does not change at any other time.
- R4: When the branch bit (word bit 12) is set, word[3:0] selects a condition, and the lowest address bit is additionally XORed with that condition as seen on the `cyc_end` clock. The selector values are: 0-6 `ir[0]`-`ir[6]`, 7 `bcarry`, 8 `pc0`, 9 `ir[15]`, 10 `memref`, 11 `ir[10]`, 12 `irq`, 13 `ir[8]`, 14 `dcarry`, 15 `io_busy`.
- R5: When the suppress bit (word bit 13) is set and the condition selected by word[3:0] is false, `shift_en` stays low for the whole body. The cycle keeps its full length. When the condition is true, the shift enables are normal.
- R6: When the A/B-to-R bit (word bit 14) is set and the R-source field (word[17:15]) is 0, the upper modifier is {`ir[14]`, `ir[13]`, `ir[12]`, `ir[11]` AND `ir[14]`} (MSB first) instead of word[3:0].
- R7: While reset is asserted, and until the first word is taken, the address is 0 and `shift_en` and `cyc_end` are low.
- R8: While `ready` is low, the sequencer stays in the overhead clock with no shift enable and no address change. Each clock of stall lengthens the cycle by one.
- R9: From the first body clock to the end of the cycle, the outputs carry the active word's fields: `r_sel`=[17:15], `s_sel`=[19:18], `alu_fn`=[22:20], `x_sel`=[25:23], `ab_to_r`=bit 14, `t_to_m`=bit 26, `t_to_t`=bit 27.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ready | input | 1 | High lets a new micro-cycle begin; low stalls in the overhead clock |
| rom_addr | output | 8 | Current micro-address to the control store |
| rom_data | input | 28 | Micro-word read at `rom_addr` |
| ir | input | 16 | Instruction register bits used as conditions and dispatch |
| bcarry | input | 1 | Binary carry condition |
| pc0 | input | 1 | Program counter bit 0 condition |
| memref | input | 1 | Memory-reference instruction class condition |
| irq | input | 1 | Interrupt pending condition |
| dcarry | input | 1 | Decimal carry condition |
| io_busy | input | 1 | I/O engine busy condition |
| shift_en | output | 1 | Shift clock enable for the serial data path |
| cyc_end | output | 1 | Last clock of the current micro-cycle |
| r_sel | output | 3 | R-bus source field |
| s_sel | output | 2 | S-bus source field |
| alu_fn | output | 3 | ALU function field |
| x_sel | output | 3 | Destination / misc field |
| ab_to_r | output | 1 | A/B register to R-bus bit |
| t_to_m | output | 1 | Result to memory-address register bit |
| t_to_t | output | 1 | Result to memory-data register bit |

## Verification
Two-way branching and shift suppression both read the single condition picked by the upper modifier. So one word that sets both the branch and suppress bits makes both act in the same cycle. The bench runs such a word with the interrupt condition held low and then high. It expects, in the first case, no shift enables and an unflipped low address bit, and in the second, a full run of shift enables and a flipped low address bit. In both cases the cycle length must stay the same.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
  localparam int HALF_W  = 4;
  localparam int ADDR_W  = 2 * HALF_W;
  localparam int LEN_W   = 4;
  localparam int NCOND   = 16;
  localparam int SEL_W   = $clog2(NCOND);
  localparam int WORD_W  = 28;

  // Field packing of the 28-bit micro-word, MSB first.
  typedef struct packed {
    logic             t2t;    // [27]
    logic             t2m;    // [26]
    logic [2:0]       xsel;   // [25:23]
    logic [2:0]       alu;    // [22:20]
    logic [1:0]       ssrc;   // [19:18]
    logic [2:0]       rsrc;   // [17:15]
    logic             xtr;    // [14]
    logic             iqn;    // [13]
    logic             brc;    // [12]
    logic [LEN_W-1:0] len;    // [11:8]
    logic [3:0]       smod;   // [7:4]
    logic [3:0]       pmod;   // [3:0]
  } uword_t;

  typedef enum logic {PH_LOAD = 1'b0, PH_BODY = 1'b1} phase_e;

  localparam logic [2:0] RSRC_ONE = 3'd0;
endpackage

// File: rtl/useq_rst_sync.sv
`timescale 1ns/1ps
module useq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/useq_cond_mux.sv
`timescale 1ns/1ps
module useq_cond_mux #(
  parameter int NCOND = 16,
  localparam int SEL_W = $clog2(NCOND)
) (
  input  logic [NCOND-1:0] conds,
  input  logic [SEL_W-1:0] sel,
  output logic             cond
);
  always_comb begin
    cond = 1'b0;
    for (int i = 0; i < NCOND; i++) begin
      if (sel == SEL_W'(i)) cond = conds[i];
    end
  end
endmodule

// File: rtl/useq_timer.sv
`timescale 1ns/1ps
module useq_timer
  import useq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready,
  input  logic [CNT_W-1:0] len,
  input  logic             suppress,
  output logic             body,
  output logic             load_en,
  output logic             cyc_end,
  output logic             shift_en
);
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             last;

  assign body     = (ph_q == PH_BODY);
  assign last     = (cnt_q == len);
  assign load_en  = (ph_q == PH_LOAD) && ready;
  assign cyc_end  = body && last;
  assign shift_en = body && !suppress;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    case (ph_q)
      PH_LOAD: begin
        if (ready) begin
          ph_d   = PH_BODY;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      PH_BODY: begin
        if (last) begin
          ph_d = PH_LOAD;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: ph_d = PH_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_LOAD;
      cnt_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/useq_addr.sv
`timescale 1ns/1ps
module useq_addr #(
  parameter int HW = 4,
  localparam int AW = 2 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [HW-1:0] pmod,
  input  logic [HW-1:0] smod,
  input  logic          brc,
  input  logic          cond,
  input  logic          qpm,
  input  logic [HW-1:0] qmod,
  output logic [AW-1:0] addr
);
  logic [HW-1:0] hi_q, hi_d;
  logic [HW-1:0] lo_q, lo_d;
  logic [HW-1:0] hi_mod;
  logic [HW-1:0] lo_mod;

  always_comb begin
    hi_mod = qpm ? qmod : pmod;
    lo_mod = smod ^ {{(HW-1){1'b0}}, brc & cond};
    hi_d   = hi_q ^ hi_mod;
    lo_d   = lo_q ^ lo_mod;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (adv) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign addr = {hi_q, lo_q};
endmodule

// File: rtl/useq_core.sv
`timescale 1ns/1ps
module useq_core
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [WORD_W-1:0] rom_data,
  input  logic [15:0]       ir,
  input  logic              bcarry,
  input  logic              pc0,
  input  logic              memref,
  input  logic              irq,
  input  logic              dcarry,
  input  logic              io_busy,
  output logic              shift_en,
  output logic              cyc_end,
  output logic [2:0]        r_sel,
  output logic [1:0]        s_sel,
  output logic [2:0]        alu_fn,
  output logic [2:0]        x_sel,
  output logic              ab_to_r,
  output logic              t_to_m,
  output logic              t_to_t
);
  logic             rst_n_s;
  uword_t           word_q;
  logic             load_en;
  logic             body;
  logic             cond_sel;
  logic             qpm;
  logic [NCOND-1:0] conds;
  logic [HALF_W-1:0] qmod;

  useq_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  // Selector order is fixed by the microcode encoding.
  assign conds = {io_busy, dcarry, ir[8], irq, ir[10], memref, ir[15],
                  pc0, bcarry, ir[6:0]};

  useq_cond_mux #(.NCOND(NCOND)) u_cmux (
    .conds (conds),
    .sel   (word_q.pmod),
    .cond  (cond_sel)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     word_q <= '0;
    else if (load_en) word_q <= uword_t'(rom_data);
  end

  useq_timer #(.CNT_W(LEN_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ready    (ready),
    .len      (word_q.len),
    .suppress (word_q.iqn & ~cond_sel),
    .body     (body),
    .load_en  (load_en),
    .cyc_end  (cyc_end),
    .shift_en (shift_en)
  );

  assign qpm  = word_q.xtr && (word_q.rsrc == RSRC_ONE);
  assign qmod = {ir[14], ir[13], ir[12], ir[11] & ir[14]};

  useq_addr #(.HW(HALF_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .adv   (cyc_end),
    .pmod  (word_q.pmod),
    .smod  (word_q.smod),
    .brc   (word_q.brc),
    .cond  (cond_sel),
    .qpm   (qpm),
    .qmod  (qmod),
    .addr  (rom_addr)
  );

  assign r_sel   = word_q.rsrc;
  assign s_sel   = word_q.ssrc;
  assign alu_fn  = word_q.alu;
  assign x_sel   = word_q.xsel;
  assign ab_to_r = word_q.xtr;
  assign t_to_m  = word_q.t2m;
  assign t_to_t  = word_q.t2t;
endmodule

// File: rtl/useq_core_chk.sv
`timescale 1ns/1ps
module useq_core_chk
  import useq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              shift_en,
  input logic              cyc_end,
  input logic [ADDR_W-1:0] rom_addr,
  input uword_t            word_q,
  input logic              body,
  input logic              cond
);
  logic [LEN_W-1:0] body_cnt;
  logic             qpm_c;

  assign qpm_c = word_q.xtr && (word_q.rsrc == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       body_cnt <= '0;
    else if (cyc_end) body_cnt <= '0;
    else if (body)    body_cnt <= body_cnt + 1'b1;
  end

  AST_BODY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |-> body_cnt == word_q.len); // R1

  AST_GAP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> !shift_en && !cyc_end); // R2

  AST_NO_SHIFT_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !body |-> !shift_en); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> $stable(rom_addr)); // R3

  AST_ADDR_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && !word_q.brc && !qpm_c |=>
      rom_addr == ($past(rom_addr) ^ {$past(word_q.pmod), $past(word_q.smod)})); // R3

  AST_BRANCH_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && word_q.brc |=>
      rom_addr[0] == ($past(rom_addr[0]) ^ $past(word_q.smod[0]) ^ $past(cond))); // R4

  AST_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    body && word_q.iqn && !cond |-> !shift_en); // R5
endmodule

bind useq_core useq_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .shift_en (shift_en),
  .cyc_end  (cyc_end),
  .rom_addr (rom_addr),
  .word_q   (word_q),
  .body     (body),
  .cond     (cond_sel)
);

// File: tb/useq_core_tb.sv
`timescale 1ns/1ps
module useq_core_tb;
  import useq_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        ready;
  logic [7:0]  rom_addr;
  logic [27:0] rom_data;
  logic [15:0] ir;
  logic        bcarry, pc0, memref, irq, dcarry, io_busy;
  logic        shift_en, cyc_end;
  logic [2:0]  r_sel, alu_fn, x_sel;
  logic [1:0]  s_sel;
  logic        ab_to_r, t_to_m, t_to_t;

  logic [27:0] rom [256];
  int checks;
  int failures;

  assign rom_data = rom[rom_addr];

  useq_core u_dut (
    .clk(clk), .rst_n(rst_n), .ready(ready), .rom_addr(rom_addr),
    .rom_data(rom_data), .ir(ir), .bcarry(bcarry), .pc0(pc0),
    .memref(memref), .irq(irq), .dcarry(dcarry), .io_busy(io_busy),
    .shift_en(shift_en), .cyc_end(cyc_end), .r_sel(r_sel), .s_sel(s_sel),
    .alu_fn(alu_fn), .x_sel(x_sel), .ab_to_r(ab_to_r), .t_to_m(t_to_m),
    .t_to_t(t_to_t)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [27:0] mkw(input logic [3:0] pm, input logic [3:0] sm,
                                      input logic [3:0] len, input logic brc,
                                      input logic iqn, input logic xtr,
                                      input logic [2:0] rs);
    uword_t w;
    w      = '0;
    w.pmod = pm;  w.smod = sm;  w.len = len;
    w.brc  = brc; w.iqn  = iqn; w.xtr = xtr;
    w.rsrc = rs;
    return w;
  endfunction

  task automatic clear_inputs();
    ir = '0; bcarry = 0; pc0 = 0; memref = 0; irq = 0; dcarry = 0; io_busy = 0;
    for (int i = 0; i < 256; i++) rom[i] = mkw(4'h0, 4'h0, 4'h0, 0, 0, 0, 3'd7);
  endtask

  task automatic start();
    ready = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
  endtask

  // Run one micro-cycle from its overhead clock; first 'stall' clocks hold ready low.
  task automatic run_cycle(input int stall, output int clks, output int shifts,
                           output logic [7:0] nxt);
    logic done;
    clks = 0; shifts = 0; done = 0;
    while (!done) begin
      ready = (clks >= stall);
      #1;
      clks++;
      if (shift_en) shifts++;
      if (cyc_end) done = 1;
      else @(negedge clk);
    end
    @(negedge clk);
    #1;
    nxt = rom_addr;
  endtask

  task automatic t_reset();
    clear_inputs();
    rst_n = 1'b0; ready = 1'b0;
    @(negedge clk);
    check("R7 addr in reset", rom_addr, 0);
    check("R7 shift_en in reset", shift_en, 0);
    check("R7 cyc_end in reset", cyc_end, 0);
    start();
    check("R7 addr after reset", rom_addr, 0);
    check("R7 shift_en idle", shift_en, 0);
  endtask

  task automatic t_length();
    int c, s;
    logic [7:0] n;
    int lens[3] = '{0, 5, 15};
    foreach (lens[k]) begin
      clear_inputs();
      rom[0] = mkw(4'h3, 4'h2, 4'(lens[k]), 0, 0, 0, 3'd7);
      start();
      run_cycle(0, c, s, n);
      check("R1 shift count", s, lens[k] + 1);
      check("R2 cycle clocks", c, lens[k] + 2);
      check("R3 next addr", n, 8'h32);
    end
    // second cycle chained from 0x32
    rom[8'h32] = mkw(4'h5, 4'hF, 4'h2, 0, 0, 0, 3'd7);
    run_cycle(0, c, s, n);
    check("R3 chained addr", n, 8'h6D);
    check("R1 chained shifts", s, 3);
  endtask

  task automatic t_branch();
    int c, s;
    logic [7:0] n;
    clear_inputs();
    rom[0] = mkw(4'h7, 4'h4, 4'h1, 1, 0, 0, 3'd7);
    bcarry = 1; start(); run_cycle(0, c, s, n);
    check("R4 bcarry true", n, 8'h75);
    bcarry = 0; start(); run_cycle(0, c, s, n);
    check("R4 bcarry false", n, 8'h74);
    rom[0] = mkw(4'hF, 4'h0, 4'h0, 1, 0, 0, 3'd7);
    io_busy = 1; start(); run_cycle(0, c, s, n);
    check("R4 io_busy sel 15", n, 8'hF1);
    io_busy = 0;
    rom[0] = mkw(4'h9, 4'h0, 4'h0, 1, 0, 0, 3'd7);
    ir = 16'h8000; start(); run_cycle(0, c, s, n);
    check("R4 ir15 sel 9", n, 8'h91);
    ir = 16'h7FFF; start(); run_cycle(0, c, s, n);
    check("R4 ir15 low sel 9", n, 8'h90);
    rom[0] = mkw(4'hB, 4'h0, 4'h0, 1, 0, 0, 3'd7);
    ir = 16'h0400; start(); run_cycle(0, c, s, n);
    check("R4 ir10 sel 11", n, 8'hB1);
    ir = 16'h0000;
    rom[0] = mkw(4'h8, 4'h0, 4'h0, 1, 0, 0, 3'd7);
    pc0 = 1; start(); run_cycle(0, c, s, n);
    check("R4 pc0 sel 8", n, 8'h81);
  endtask

  task automatic t_suppress_branch();
    int c, s;
    logic [7:0] n;
    clear_inputs();
    rom[0] = mkw(4'hC, 4'h6, 4'h7, 1, 1, 0, 3'd7);
    irq = 0; start(); run_cycle(0, c, s, n);
    check("R5 suppressed shifts", s, 0);
    check("R5 suppressed length", c, 9);
    check("R4 no flip", n, 8'hC6);
    irq = 1; start(); run_cycle(0, c, s, n);
    check("R5 enabled shifts", s, 8);
    check("R5 enabled length", c, 9);
    check("R4 flip", n, 8'hC7);
    rom[0] = mkw(4'hE, 4'h0, 4'h3, 0, 1, 0, 3'd7);
    irq = 0; dcarry = 0; start(); run_cycle(0, c, s, n);
    check("R5 no branch suppress", s, 0);
    check("R3 addr with suppress", n, 8'hE0);
  endtask

  task automatic t_dispatch();
    int c, s;
    logic [7:0] n;
    clear_inputs();
    rom[0] = mkw(4'hA, 4'h0, 4'h0, 0, 0, 1, 3'd0);
    ir = 16'h5800; start(); run_cycle(0, c, s, n);   // 14,12,11 set
    check("R6 dispatch B", n, 8'hB0);
    ir = 16'h2800; start(); run_cycle(0, c, s, n);   // 13,11 set, 14 clear
    check("R6 dispatch 4", n, 8'h40);
    rom[0] = mkw(4'hA, 4'h0, 4'h0, 0, 0, 1, 3'd1);
    start(); run_cycle(0, c, s, n);
    check("R6 no dispatch when rsrc!=0", n, 8'hA0);
  endtask

  task automatic t_ready();
    int c, s;
    logic [7:0] n;
    clear_inputs();
    rom[0] = mkw(4'h1, 4'h1, 4'h2, 0, 0, 0, 3'd7);
    start();
    run_cycle(3, c, s, n);
    check("R8 stalled length", c, 7);
    check("R8 stalled shifts", s, 3);
    check("R8 addr after stall", n, 8'h11);
  endtask

  task automatic t_fields();
    uword_t w;
    clear_inputs();
    w = uword_t'(mkw(4'h0, 4'h0, 4'h2, 0, 0, 1, 3'd5));
    w.ssrc = 2'd2; w.alu = 3'd6; w.xsel = 3'd4; w.t2m = 1; w.t2t = 0;
    rom[0] = w;
    start();
    ready = 1; @(negedge clk); #1;   // first body clock
    check("R9 r_sel", r_sel, 5);
    check("R9 s_sel", s_sel, 2);
    check("R9 alu_fn", alu_fn, 6);
    check("R9 x_sel", x_sel, 4);
    check("R9 ab_to_r", ab_to_r, 1);
    check("R9 t_to_m", t_to_m, 1);
    check("R9 t_to_t", t_to_t, 0);
    check("R1 first body shift", shift_en, 1);
  endtask

  initial begin
    checks = 0; failures = 0;
    t_reset();
    t_length();
    t_branch();
    t_suppress_branch();
    t_dispatch();
    t_ready();
    t_fields();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule